// File: doc/BRIEF.md
# Target Wait-State and Retry Controller

This block sits on the target side of a bridge between a PCI-style system bus and a local bus. Once a transaction has been claimed, it decides each clock whether the current data phase completes (TRDY# low), waits (TRDY# high), ends with a disconnect (STOP# and TRDY# low together), or gives up with a Retry (STOP# low, TRDY# high). It bases the decision on whether the local bus has been granted, on the write FIFO's full and one-slot-left flags, on the read FIFO's empty flag, and on a mode bit that selects disconnect or wait states when writes fill the FIFO.

A hold-off timer bounds how long the master may be kept waiting. The timer holds a 4-bit delay field multiplied by eight bus clocks. It restarts at the start of each transaction and on every completed data phase. When it expires during a hold-off, the target issues a Retry. A delay of zero turns the timer off. All three outputs come straight from flops.

Top module: `tgt_holdoff_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, trdy_n=1, stop_n=1 and term_code=2'b00 (none).
- R2: During a read data phase, trdy_n goes low in the cycle after a clock edge that samples local_grant=1 and rfifo_empty=0. While either condition is missing it stays high.
- R3: With retry_dly=d (d≠0), 8·d consecutive hold-off cycles since the last load produce stop_n=0, trdy_n=1 and term_code=2'b10 (retry).
- R4: During a write, while wfifo_full=1, trdy_n stays high (wait states) and no STOP# is issued until the timer runs out.
- R5: While local_grant=0, every data phase is held off, and the timeout ends it in the same Retry as a slow FIFO does.
- R6: Each data phase that completes with trdy_n=0 reloads the timer, so a new full window of 8·d hold-off cycles must pass before a Retry.
- R7: With retry_dly=0, the target holds off indefinitely and never retries.
- R8: When disc_mode=1, a write phase accepted while wfifo_afull=1 (one slot left) is signalled with trdy_n=0, stop_n=0 and term_code=2'b01 (disconnect). After that, trdy_n=1 while stop_n stays 0.
- R9: stop_n stays low until frame_n is sampled high. In the following cycle the outputs are deasserted and term_code returns to 2'b00.
- R10: When disc_mode=0, a write accepted while wfifo_afull=1 completes normally (trdy_n=0, stop_n=1), and the phases after it wait on wfifo_full.
- R11: txn_start is acted on only while idle and with frame_n low. The direction is captured from txn_write at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Transaction active while low |
| txn_start | input | 1 | Pulse: transaction claimed, data phases begin |
| txn_write | input | 1 | Direction at start: 1 write, 0 read |
| wfifo_full | input | 1 | Write FIFO has no free slot |
| wfifo_afull | input | 1 | Write FIFO has exactly one free slot |
| rfifo_empty | input | 1 | Read FIFO holds no data |
| local_grant | input | 1 | Local bus is owned by the bridge |
| disc_mode | input | 1 | 1: disconnect when writes fill FIFO, 0: wait states |
| retry_dly | input | 4 | Hold-off limit in units of 8 clocks, 0 disables |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| term_code | output | 2 | 00 none, 01 disconnect, 10 retry |

## Verification
A timer that is off by one count moves the fall of stop_n by one clock. The bench checks the exact cycle of 8·d hold-off cycles, both from the start and after a reload, so the error shows within one window. A direction or readiness flop holding the wrong value shows up as trdy_n asserting, or failing to assert, on the first data phase after the flag changes. A terminating state that fails to release, or releases too early, appears at stop_n within one clock of frame_n rising.

// File: rtl/tgt_holdoff_pkg.sv
package tgt_holdoff_pkg;
  typedef enum logic [1:0] {
    TERM_NONE  = 2'b00,
    TERM_DISC  = 2'b01,
    TERM_RETRY = 2'b10
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DATA = 2'b01,
    ST_STOP = 2'b10
  } phase_e;
endpackage

// File: rtl/tgt_holdoff_timer.sv
module tgt_holdoff_timer #(
  parameter int DLY_W     = 4,
  parameter int UNIT_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             expire
);
  localparam int SHIFT = $clog2(UNIT_CLKS);
  localparam int CNT_W = DLY_W + SHIFT;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(((1 << DLY_W) - 1) * UNIT_CLKS);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  assign expire = tick && en_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (load) begin
      cnt_q <= CNT_W'(dly) * CNT_W'(UNIT_CLKS);
      en_q  <= (dly != '0);
    end else if (tick && en_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX); // R3
  AST_ZERO_NEVER_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    (load && dly == '0) |=> !expire); // R7
endmodule

// File: rtl/tgt_phase_decide.sv
module tgt_phase_decide (
  input  logic is_write,
  input  logic wfifo_full,
  input  logic wfifo_afull,
  input  logic rfifo_empty,
  input  logic local_grant,
  input  logic disc_mode,
  output logic ready,
  output logic disc_now
);
  logic path_ok;

  always_comb begin
    if (is_write) path_ok = !wfifo_full;
    else          path_ok = !rfifo_empty;
    ready    = local_grant && path_ok;
    disc_now = ready && is_write && wfifo_afull && disc_mode;
  end
endmodule

// File: rtl/tgt_holdoff_ctrl.sv
module tgt_holdoff_ctrl
  import tgt_holdoff_pkg::*;
#(
  parameter int DLY_W     = 4,
  parameter int UNIT_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             txn_start,
  input  logic             txn_write,
  input  logic             wfifo_full,
  input  logic             wfifo_afull,
  input  logic             rfifo_empty,
  input  logic             local_grant,
  input  logic             disc_mode,
  input  logic [DLY_W-1:0] retry_dly,
  output logic             trdy_n,
  output logic             stop_n,
  output logic [1:0]       term_code
);
  phase_e st_q;
  logic   dir_q;
  logic   ready, disc_now, expire;
  logic   t_load, t_tick;

  tgt_phase_decide u_decide (
    .is_write    (dir_q),
    .wfifo_full  (wfifo_full),
    .wfifo_afull (wfifo_afull),
    .rfifo_empty (rfifo_empty),
    .local_grant (local_grant),
    .disc_mode   (disc_mode),
    .ready       (ready),
    .disc_now    (disc_now)
  );

  always_comb begin
    t_load = 1'b0;
    t_tick = 1'b0;
    if (st_q == ST_IDLE) begin
      t_load = txn_start && !frame_n;
    end else if (st_q == ST_DATA && !frame_n) begin
      t_load = ready;
      t_tick = !ready;
    end
  end

  tgt_holdoff_timer #(.DLY_W(DLY_W), .UNIT_CLKS(UNIT_CLKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (t_load),
    .tick   (t_tick),
    .dly    (retry_dly),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      dir_q     <= 1'b0;
      trdy_n    <= 1'b1;
      stop_n    <= 1'b1;
      term_code <= TERM_NONE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          trdy_n    <= 1'b1;
          stop_n    <= 1'b1;
          term_code <= TERM_NONE;
          if (txn_start && !frame_n) begin
            st_q  <= ST_DATA;
            dir_q <= txn_write;
          end
        end
        ST_DATA: begin
          if (frame_n) begin
            st_q   <= ST_IDLE;
            trdy_n <= 1'b1;
            stop_n <= 1'b1;
          end else if (disc_now) begin
            st_q      <= ST_STOP;
            trdy_n    <= 1'b0;
            stop_n    <= 1'b0;
            term_code <= TERM_DISC;
          end else if (ready) begin
            trdy_n <= 1'b0;
          end else if (expire) begin
            st_q      <= ST_STOP;
            trdy_n    <= 1'b1;
            stop_n    <= 1'b0;
            term_code <= TERM_RETRY;
          end else begin
            trdy_n <= 1'b1;
          end
        end
        default: begin
          trdy_n <= 1'b1;
          if (frame_n) begin
            st_q      <= ST_IDLE;
            stop_n    <= 1'b1;
            term_code <= TERM_NONE;
          end else begin
            stop_n <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_RETRY_NO_TRDY: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && term_code == TERM_RETRY) |-> trdy_n); // R3
  AST_DISC_WITH_TRDY: assert property (@(posedge clk) disable iff (rst)
    ($fell(stop_n) && term_code == TERM_DISC) |-> !trdy_n); // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && !frame_n) |=> !stop_n); // R9
  AST_IDLE_TERM_NONE: assert property (@(posedge clk) disable iff (rst)
    stop_n |-> term_code == TERM_NONE); // R9
  AST_NO_RETRY_ZERO_DLY: assert property (@(posedge clk) disable iff (rst)
    ($fell(stop_n) && trdy_n) |-> $past(retry_dly) != '0); // R7
endmodule

// File: tb/tgt_holdoff_ctrl_bench.sv
module tgt_holdoff_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_n = 1'b1, txn_start = 1'b0, txn_write = 1'b0;
  logic       wfifo_full = 1'b0, wfifo_afull = 1'b0, rfifo_empty = 1'b1;
  logic       local_grant = 1'b0, disc_mode = 1'b0;
  logic [3:0] retry_dly = 4'd0;
  logic       trdy_n, stop_n;
  logic [1:0] term_code;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic       trdy;
    logic       stop;
    logic [1:0] term;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  tgt_holdoff_ctrl u_tgt_holdoff_ctrl (
    .clk(clk), .rst(rst), .frame_n(frame_n), .txn_start(txn_start),
    .txn_write(txn_write), .wfifo_full(wfifo_full), .wfifo_afull(wfifo_afull),
    .rfifo_empty(rfifo_empty), .local_grant(local_grant), .disc_mode(disc_mode),
    .retry_dly(retry_dly), .trdy_n(trdy_n), .stop_n(stop_n), .term_code(term_code)
  );

  // Monitor: compares outputs 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      compared++;
      if (trdy_n !== e.trdy || stop_n !== e.stop || term_code !== e.term) begin
        mismatched++;
        $display("FAIL %s: got trdy_n=%b stop_n=%b term=%b, expected trdy_n=%b stop_n=%b term=%b",
                 e.tag, trdy_n, stop_n, term_code, e.trdy, e.stop, e.term);
      end
    end
  end

  // Driver: sets inputs on falling edge, pushes outputs expected after next rising edge
  task automatic step(input logic st, input logic fr, input logic wf, input logic waf,
                      input logic re, input logic gr, input logic et, input logic es,
                      input logic [1:0] eterm, input string tag);
    @(negedge clk);
    txn_start = st; frame_n = fr; wfifo_full = wf; wfifo_afull = waf;
    rfifo_empty = re; local_grant = gr;
    sb_q.push_back('{et, es, eterm, tag});
  endtask

  task automatic finish_txn(input string tag);
    step(0, 1, 0, 0, 1, 1, 1, 1, 2'b00, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: got no finish, expected finish before 100000 cycles");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    sb_q.push_back('{1'b1, 1'b1, 2'b00, "R1 reset state"});
    @(negedge clk);
    rst = 1'b0;

    // R2: read held off until data available, then TRDY#
    txn_write = 0; retry_dly = 4'd2;
    step(1, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R11 read start");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R2 read wait");
    step(0, 0, 0, 0, 0, 1, 0, 1, 2'b00, "R2 read data ready");
    finish_txn("R9 read end idle");

    // R11: start ignored while frame_n high
    step(1, 1, 0, 0, 0, 1, 1, 1, 2'b00, "R11 start with frame high");
    step(0, 0, 0, 0, 0, 1, 1, 1, 2'b00, "R11 no data phase without start");
    finish_txn("R11 idle");

    // R3: read retry after 8*1 cycles, R9 stop held then released
    retry_dly = 4'd1;
    step(1, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R3 start");
    for (int i = 1; i < 8; i++) step(0, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R3 pre-timeout");
    step(0, 0, 0, 0, 1, 1, 1, 0, 2'b10, "R3 retry issued");
    step(0, 0, 0, 0, 0, 1, 1, 0, 2'b10, "R9 stop held while frame low");
    finish_txn("R9 release after frame high");

    // R5: no local grant, write direction, retry at 16 cycles (d=2)
    txn_write = 1; retry_dly = 4'd2;
    step(1, 0, 0, 0, 1, 0, 1, 1, 2'b00, "R5 start");
    for (int i = 1; i < 16; i++) step(0, 0, 0, 0, 1, 0, 1, 1, 2'b00, "R5 no grant wait");
    step(0, 0, 0, 0, 1, 0, 1, 0, 2'b10, "R5 retry no grant");
    finish_txn("R9 end");

    // R4 + R6: write FIFO full, wait mode, reload after one accepted phase
    disc_mode = 0; retry_dly = 4'd1;
    step(1, 0, 1, 0, 1, 1, 1, 1, 2'b00, "R4 start");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 1, 1, 1, 1, 2'b00, "R4 full wait state");
    step(0, 0, 0, 0, 1, 1, 0, 1, 2'b00, "R6 accepted phase");
    for (int i = 1; i < 8; i++) step(0, 0, 1, 0, 1, 1, 1, 1, 2'b00, "R6 window restarted");
    step(0, 0, 1, 0, 1, 1, 1, 0, 2'b10, "R4 retry after slow drain");
    finish_txn("R9 end");

    // R7: zero delay never retries
    retry_dly = 4'd0; txn_write = 0;
    step(1, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R7 start");
    for (int i = 0; i < 200; i++) step(0, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R7 no timeout");
    step(0, 0, 0, 0, 0, 1, 0, 1, 2'b00, "R7 late data");
    finish_txn("R9 end");

    // R8: disconnect with data when one slot left
    txn_write = 1; disc_mode = 1; retry_dly = 4'd3;
    step(1, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R8 start");
    step(0, 0, 0, 0, 1, 1, 0, 1, 2'b00, "R8 normal write");
    step(0, 0, 0, 1, 1, 1, 0, 0, 2'b01, "R8 disconnect with data");
    step(0, 0, 1, 0, 1, 1, 1, 0, 2'b01, "R8 stop held trdy off");
    step(0, 0, 1, 0, 1, 1, 1, 0, 2'b01, "R9 stop held");
    finish_txn("R9 release after disconnect");

    // R10: wait mode accepts the filling write, then waits
    disc_mode = 0;
    step(1, 0, 0, 0, 1, 1, 1, 1, 2'b00, "R10 start");
    step(0, 0, 0, 1, 1, 1, 0, 1, 2'b00, "R10 filling write accepted");
    step(0, 0, 1, 0, 1, 1, 1, 1, 2'b00, "R10 wait on full");
    finish_txn("R9 end");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule